// File: doc/BRIEF.md
# Start-up and VID Slew Sequencer

This block generates the digital reference code for a multiphase core regulator and steps it from power-on to regulation. Once the supply monitor reports good supply and the enable pin is high, it waits a fixed number of time-base ticks. It then ramps the reference at a slow rate up to a fixed 1.200 V boot level. When the measured output has stayed near that level for enough switching cycles, the active-low clock-enable pin is driven low. The reference then moves to the level requested by the 7-bit voltage-identification (VID) code, and power-good follows after a long delay.

The reference is kept in fine units of 0.78125 mV (one VID LSB of 12.5 mV split into 16), so every per-tick step is an integer. After start-up the block keeps following VID changes on the fly. It steps at a fast rate when the deeper-sleep input is low and at the slow rate when it is high, and it never passes the target. All pins are plain level or strobe signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `vref_sequencer`

## Requirements
- R1: After reset, and while supply-good or enable is low, `vref` is 0, `clk_en_n` is 1 and `pgood` is 0.
- R2: When `por_ok` and `enable` are both high, the reference stays at 0 for DELAY_TICKS ticks (120 by default). After that wait the boot ramp begins.
- R3: During the boot ramp, each tick raises `vref` by SLOW_STEP units (3, about 2.3 mV). The ramp ends exactly on the boot code 1536 (1.200 V) without passing it.
- R4: Once the boot code is reached, `clk_en_n` falls after QUAL_CYCLES (13) consecutive `cyc_stb` strobes that each see `meas` within 10 % of boot (1383..1689 inclusive). A strobe outside that window restarts the count, and `vref` equals 1536 when `clk_en_n` falls.
- R5: While `clk_en_n` is low, each tick moves `vref` toward the VID target by FAST_STEP units (13, about 10.2 mV) when `dslp` is 0, or by SLOW_STEP when `dslp` is 1. It stops exactly on the target.
- R6: `pgood` rises PG_TICKS ticks (7000 by default) after `clk_en_n` falls, and it is never high while `clk_en_n` is high.
- R7: VID code c (bit 6 most significant) with c ≤ 96 gives a target of (120 − c) × 16 units, which is 1.500 V − c × 12.5 mV. Codes above 96 give target 0 (output off).
- R8: A VID change after start-up is followed at the rate selected by `dslp`, without a new start-up.
- R9: Dropping `enable` or `por_ok` at any point returns the block to idle on the next clock: `vref` goes to 0, `clk_en_n` to 1 and `pgood` to 0.
- R10: `vref` changes only on clocks where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| tick | input | 1 | Time-base strobe, one clock wide, nominally every 1 µs |
| por_ok | input | 1 | Supply above power-on threshold |
| enable | input | 1 | Regulator enable |
| vid | input | 7 | Voltage-identification code |
| dslp | input | 1 | Deeper-sleep input, selects slow slew when high |
| cyc_stb | input | 1 | One strobe per switching cycle |
| meas | input | 11 | Measured output in reference units |
| vref | output | 11 | Reference code, 0.78125 mV per unit |
| clk_en_n | output | 1 | Active-low clock enable |
| pgood | output | 1 | Power good |

## Verification
On every cycle, the assertions check four things: the idle state after a drop of enable or supply, the step-size bound and hold-without-tick on `vref`, that the reference never overshoots while ramping, and that power-good never leads clock-enable. They also check that the qualification count restarts on an out-of-window strobe and that `vref` sits at the boot code when `clk_en_n` falls. Only the bench scenarios can show the exact number of ticks in the start wait and the power-good delay, and the decoded VID targets including the off codes. The same holds for the switch between fast and slow slew on a live VID change and for the mid-ramp supply loss.

// File: rtl/vref_seq_pkg.sv
package vref_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_WAIT  = 3'd1,
    SQ_BOOT  = 3'd2,
    SQ_QUAL  = 3'd3,
    SQ_TRACK = 3'd4
  } seq_state_t;

endpackage

// File: rtl/seq_vid_decode.sv
module seq_vid_decode #(
  parameter int VID_W    = 7,
  parameter int REF_W    = 11,
  parameter int SUB      = 16,
  parameter int TOP_LSBS = 120,
  parameter int MIN_LSBS = 24
) (
  input  logic [VID_W-1:0] code,
  output logic [REF_W-1:0] tgt
);
  localparam int LAST_CODE = TOP_LSBS - MIN_LSBS;

  always_comb begin
    if (int'(code) > LAST_CODE) tgt = '0;
    else                        tgt = REF_W'((TOP_LSBS - int'(code)) * SUB);
  end
endmodule

// File: rtl/seq_slewer.sv
module seq_slewer #(
  parameter int REF_W = 11
) (
  input  logic [REF_W-1:0] cur,
  input  logic [REF_W-1:0] tgt,
  input  logic [REF_W-1:0] step,
  output logic [REF_W-1:0] nxt
);
  logic [REF_W-1:0] gap;

  always_comb begin
    if (cur < tgt) begin
      gap = tgt - cur;
      nxt = (gap <= step) ? tgt : cur + step;
    end else if (cur > tgt) begin
      gap = cur - tgt;
      nxt = (gap <= step) ? tgt : cur - step;
    end else begin
      gap = '0;
      nxt = cur;
    end
  end

  always_comb begin
    AST_NO_OVERSHOOT: assert ((cur > tgt) || (nxt <= tgt && nxt >= cur)); // R3
  end
endmodule

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int LIMIT = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (tick && !done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && run) |=> done); // R6
endmodule

// File: rtl/seq_qualifier.sv
module seq_qualifier #(
  parameter int REF_W   = 11,
  parameter int BOOT    = 1536,
  parameter int WIN_PCT = 10,
  parameter int NCYC    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cyc_stb,
  input  logic [REF_W-1:0] meas,
  output logic             pass
);
  localparam int WIN = (BOOT * WIN_PCT) / 100;
  localparam logic [REF_W-1:0] LO = REF_W'(BOOT - WIN);
  localparam logic [REF_W-1:0] HI = REF_W'(BOOT + WIN);
  localparam int CW = (NCYC < 2) ? 1 : $clog2(NCYC);
  localparam logic [CW-1:0] LAST = CW'(NCYC - 1);

  logic [CW-1:0] cnt;
  logic          inwin;

  assign inwin = (meas >= LO) && (meas <= HI);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      pass <= 1'b0;
    end else if (cyc_stb) begin
      if (inwin) begin
        if (cnt == LAST) pass <= 1'b1;
        else             cnt  <= cnt + 1'b1;
      end else begin
        cnt  <= '0;
        pass <= 1'b0;
      end
    end
  end

  AST_QUAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc_stb && !inwin) |=> !pass); // R4
endmodule

// File: rtl/vref_sequencer.sv
module vref_sequencer
  import vref_seq_pkg::*;
#(
  parameter int VID_W       = 7,
  parameter int REF_W       = 11,
  parameter int SUB         = 16,
  parameter int TOP_LSBS    = 120,
  parameter int MIN_LSBS    = 24,
  parameter int BOOT_LSBS   = 96,
  parameter int SLOW_STEP   = 3,
  parameter int FAST_STEP   = 13,
  parameter int DELAY_TICKS = 120,
  parameter int QUAL_CYCLES = 13,
  parameter int WIN_PCT     = 10,
  parameter int PG_TICKS    = 7000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             por_ok,
  input  logic             enable,
  input  logic [VID_W-1:0] vid,
  input  logic             dslp,
  input  logic             cyc_stb,
  input  logic [REF_W-1:0] meas,
  output logic [REF_W-1:0] vref,
  output logic             clk_en_n,
  output logic             pgood
);
  localparam int BOOT_I = BOOT_LSBS * SUB;
  localparam logic [REF_W-1:0] BOOT_REF = REF_W'(BOOT_I);
  localparam logic [REF_W-1:0] SLOW_REF = REF_W'(SLOW_STEP);
  localparam logic [REF_W-1:0] FAST_REF = REF_W'(FAST_STEP);

  seq_state_t       state;
  logic             go;
  logic             wait_done, qual_pass, pg_done;
  logic [REF_W-1:0] vid_tgt, slew_tgt, slew_step, slew_nxt;

  assign go = por_ok && enable;

  seq_vid_decode #(
    .VID_W(VID_W), .REF_W(REF_W), .SUB(SUB),
    .TOP_LSBS(TOP_LSBS), .MIN_LSBS(MIN_LSBS)
  ) u_dec (
    .code(vid),
    .tgt (vid_tgt)
  );

  always_comb begin
    if (state == SQ_BOOT) begin
      slew_tgt  = BOOT_REF;
      slew_step = SLOW_REF;
    end else begin
      slew_tgt  = vid_tgt;
      slew_step = dslp ? SLOW_REF : FAST_REF;
    end
  end

  seq_slewer #(.REF_W(REF_W)) u_slew (
    .cur (vref),
    .tgt (slew_tgt),
    .step(slew_step),
    .nxt (slew_nxt)
  );

  seq_tick_timer #(.LIMIT(DELAY_TICKS)) u_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (go && state == SQ_WAIT),
    .tick (tick),
    .done (wait_done)
  );

  seq_qualifier #(
    .REF_W(REF_W), .BOOT(BOOT_I), .WIN_PCT(WIN_PCT), .NCYC(QUAL_CYCLES)
  ) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (go && state == SQ_QUAL),
    .cyc_stb(cyc_stb),
    .meas   (meas),
    .pass   (qual_pass)
  );

  seq_tick_timer #(.LIMIT(PG_TICKS)) u_pg (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (go && state == SQ_TRACK),
    .tick (tick),
    .done (pg_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !go) begin
      state <= SQ_IDLE;
      vref  <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: state <= SQ_WAIT;
        SQ_WAIT: if (wait_done) state <= SQ_BOOT;
        SQ_BOOT: if (tick) begin
          vref <= slew_nxt;
          if (slew_nxt == BOOT_REF) state <= SQ_QUAL;
        end
        SQ_QUAL: if (qual_pass) state <= SQ_TRACK;
        SQ_TRACK: if (tick) vref <= slew_nxt;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign clk_en_n = (state != SQ_TRACK);
  assign pgood    = pg_done;

  AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (vref == '0 && clk_en_n && !pgood)); // R9
  AST_PG_AFTER_CLKEN: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> !clk_en_n); // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go)) |->
      (((vref >= $past(vref)) ? (vref - $past(vref)) : ($past(vref) - vref)) <= FAST_REF)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !tick) |=> $stable(vref)); // R10
  AST_BOOT_AT_CLKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_n) |-> (vref == BOOT_REF)); // R4
endmodule

// File: tb/sim_vref_sequencer.sv
module sim_vref_sequencer;
  localparam int DLY  = 8;
  localparam int PGT  = 40;
  localparam int QN   = 13;
  localparam int SLOW = 3;
  localparam int FAST = 13;
  localparam int BOOT = 1536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        por_ok = 1'b0;
  logic        enable = 1'b0;
  logic [6:0]  vid = 7'd8;
  logic        dslp = 1'b0;
  logic        cyc_stb = 1'b0;
  logic [10:0] meas = '0;
  logic [10:0] vref;
  logic        clk_en_n;
  logic        pgood;

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  bit tick_en = 1'b1;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  vref_sequencer #(.DELAY_TICKS(DLY), .PG_TICKS(PGT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .por_ok(por_ok), .enable(enable),
    .vid(vid), .dslp(dslp), .cyc_stb(cyc_stb), .meas(meas),
    .vref(vref), .clk_en_n(clk_en_n), .pgood(pgood)
  );

  function automatic int exp_target(input int code);
    return (code > 96) ? 0 : (120 - code) * 16;
  endfunction

  function automatic int approach(input int cur, input int tgt, input int st);
    if (cur < tgt) return (tgt - cur <= st) ? tgt : cur + st;
    if (cur > tgt) return (cur - tgt <= st) ? tgt : cur - st;
    return cur;
  endfunction

  // behavioural reference: 0 idle, 1 wait, 2 boot ramp, 3 qualify, 4 track
  int m_state = 0, m_vref = 0, m_wcnt = 0, m_qcnt = 0, m_pcnt = 0;
  bit m_wdone = 0, m_qpass = 0, m_pdone = 0;

  always @(posedge clk) begin
    int os;
    bit wd, qp;
    os = m_state; wd = m_wdone; qp = m_qpass;
    if (!rst_n || !(por_ok && enable)) begin
      m_state = 0; m_vref = 0; m_wcnt = 0; m_qcnt = 0; m_pcnt = 0;
      m_wdone = 0; m_qpass = 0; m_pdone = 0;
    end else begin
      case (os)
        0: m_state = 1;
        1: if (wd) m_state = 2;
        2: if (tick) begin
             m_vref = approach(m_vref, BOOT, SLOW);
             if (m_vref == BOOT) m_state = 3;
           end
        3: if (qp) m_state = 4;
        default: if (tick) m_vref = approach(m_vref, exp_target(int'(vid)), dslp ? SLOW : FAST);
      endcase
      if (os != 1) begin m_wcnt = 0; m_wdone = 0; end
      else if (tick && !m_wdone) begin
        if (m_wcnt == DLY - 1) m_wdone = 1; else m_wcnt++;
      end
      if (os != 3) begin m_qcnt = 0; m_qpass = 0; end
      else if (cyc_stb) begin
        if (int'(meas) >= 1383 && int'(meas) <= 1689) begin
          if (m_qcnt == QN - 1) m_qpass = 1; else m_qcnt++;
        end else begin m_qcnt = 0; m_qpass = 0; end
      end
      if (os != 4) begin m_pcnt = 0; m_pdone = 0; end
      else if (tick && !m_pdone) begin
        if (m_pcnt == PGT - 1) m_pdone = 1; else m_pcnt++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, ncyc);
    end
  endtask

  function automatic string phase_tag(input int s);
    case (s)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison against the model, then stimulus strobes
  always @(negedge clk) begin
    ncyc++;
    if (rst_n && !done_flag) begin
      check(phase_tag(m_state), int'(vref), m_vref);
      check("R4 clk_en_n", int'(clk_en_n), (m_state == 4) ? 0 : 1);
      check("R6 pgood", int'(pgood), int'(m_pdone));
    end
    tick    <= tick_en && (ncyc % 2 == 0);
    cyc_stb <= (ncyc % 5 == 0);
  end

  always @(negedge clk) begin
    if (ncyc > 150000 && !done_flag) begin
      done_flag = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_state(input int s, input int lim);
    for (int k = 0; k < lim && m_state != s; k++) @(negedge clk);
  endtask

  task automatic wait_vref(input int v, input int lim);
    for (int k = 0; k < lim && m_vref != v; k++) @(negedge clk);
  endtask

  initial begin
    int held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 vref", int'(vref), 0);
    check("R1 clk_en_n", int'(clk_en_n), 1);
    check("R1 pgood", int'(pgood), 0);

    // start-up with measurement out of window
    vid = 7'd8; dslp = 1'b0; meas = 11'd0;
    por_ok = 1'b1; enable = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 held at zero", int'(vref), 0);
    wait_state(3, 6000);
    check("R3 boot level", int'(vref), BOOT);
    meas = 11'd1696;
    repeat (40) @(negedge clk);
    check("R4 out of window keeps clk_en_n", int'(clk_en_n), 1);
    meas = 11'd1386;
    repeat (30) @(negedge clk);
    meas = 11'd1690;
    repeat (6) @(negedge clk);
    meas = 11'd1536;
    repeat (40) @(negedge clk);
    check("R4 restart after out-of-window strobe", int'(clk_en_n), 1);
    wait_state(4, 2000);
    @(negedge clk);
    check("R4 clk_en_n low", int'(clk_en_n), 0);

    // fast slew to 1.400 V
    wait_vref(exp_target(8), 2000);
    check("R5 fast target", int'(vref), 1792);
    // on-the-fly change in sleep, slow slew
    dslp = 1'b1; vid = 7'd40;
    repeat (20) @(negedge clk);
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
    held = int'(vref);
    repeat (12) @(negedge clk);
    check("R10 no tick no change", int'(vref), held);
    tick_en = 1'b1;
    wait_vref(exp_target(40), 2000);
    check("R8 slow target", int'(vref), 1280);
    wait_state(4, 10);
    for (int k = 0; k < 400 && !m_pdone; k++) @(negedge clk);
    @(negedge clk);
    check("R6 pgood high", int'(pgood), 1);

    // off code and lowest code
    dslp = 1'b0; vid = 7'd100;
    wait_vref(0, 2000);
    @(negedge clk);
    check("R7 off code", int'(vref), 0);
    vid = 7'd96;
    wait_vref(exp_target(96), 2000);
    @(negedge clk);
    check("R7 lowest code", int'(vref), 384);
    vid = 7'd0;
    wait_vref(exp_target(0), 2000);
    @(negedge clk);
    check("R7 highest code", int'(vref), 1920);

    // disable drop
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 vref after disable", int'(vref), 0);
    check("R9 clk_en_n after disable", int'(clk_en_n), 1);
    check("R9 pgood after disable", int'(pgood), 0);

    // supply loss mid-ramp
    enable = 1'b1;
    wait_state(2, 200);
    repeat (60) @(negedge clk);
    por_ok = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 vref after supply loss", int'(vref), 0);
    check("R9 clk_en_n after supply loss", int'(clk_en_n), 1);

    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule